// File: doc/BRIEF.md
# Per-Slave Security Gate for a Request/Response Interconnect Port

This block sits between one interconnect master port and a group of up to sixteen memory-mapped slaves. Every request carries a secure/nonsecure attribute. The gate picks the target slave from a fixed address field and checks the request against two programmable bits for that slave. The first is a security bit, which marks the slave as reachable only by secure masters. The second is a privilege-filter bit, which makes the slave accept secure traffic only. A permitted request goes downstream unchanged, and the slave's response comes back to the master. A refused request never leaves the block. The gate answers it locally in the next cycle. By default the answer is OKAY with pseudo-random read data. When the global error enable is set, the answer is an error status instead.

Software programs the gate through a small register bank that sits at slave index 15. Only secure writes can change it. Its own access rule is the security bit and filter bit at index 15, so a nonsecure read of a protected bank returns random data, not the settings. Both channels use valid/ready. The master may hold `req_valid` with stable fields for as long as it likes. `req_ready` is high only while the gate has nothing in flight, so only one request is ever outstanding. A response stays valid with stable fields until `rsp_ready` takes it. The downstream port follows the same rules in the other direction.

Top module: `sec_gate`

## Requirements
- R1: After reset every security bit reads 1 (secure). The privilege-filter mask reads the parameter PRIV_RST (default 16'h0F00, so slaves 8 to 11 are secure-only). The error enable reads 0.
- R2: A nonsecure request to a slave whose security bit is 1 is refused. No downstream request is issued for it.
- R3: A secure request to any slave other than 15 is issued downstream with address, write flag, write data and attribute unchanged. The slave's read data and error flag are returned to the master, whatever the slave's two bits hold.
- R4: A register-bank write changes the bank only when it is secure and permitted. A nonsecure write leaves all bank contents unchanged.
- R5: A nonsecure read of the register bank while its bit 15 is secure returns LFSR data rather than the register value.
- R6: A refused request gets a local response. With the error enable clear, it is OKAY (`rsp_err`=0) and a refused read returns the current LFSR value. With the enable set, `rsp_err`=1 and `rsp_rdata`=0. Refused writes always return data 0.
- R7: A privilege-filter bit of 1 refuses nonsecure requests to that slave even when its security bit is 0.
- R8: Random data comes from a free-running 32-bit maximal-length LFSR (polynomial x^32+x^22+x^2+x+1) with a nonzero seed. It advances every cycle, so it is never zero and back-to-back refused reads give different data.
- R9: A refused request, and any request to the register bank, raises `rsp_valid` in the cycle after the request is accepted.
- R10: The slave index is `req_addr[15:12]`, and index 15 is the register bank. In the bank, `req_addr[3:2]` selects: 0 = security bits [15:0], 1 = filter mask [15:0], 2 = error enable in bit 0, 3 = reads 0.
- R11: `req_ready` is high only while idle. A response held by a low `rsp_ready`, and a downstream request held by a low `dn_req_ready`, keep all fields stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Master request valid |
| req_ready | output | 1 | Gate can accept a request |
| req_addr | input | 32 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | 1 = secure attribute |
| rsp_valid | output | 1 | Response valid to master |
| rsp_ready | input | 1 | Master takes the response |
| rsp_rdata | output | 32 | Response read data |
| rsp_err | output | 1 | Response error status |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Slave accepts downstream request |
| dn_addr | output | 32 | Downstream address |
| dn_write | output | 1 | Downstream write flag |
| dn_wdata | output | 32 | Downstream write data |
| dn_secure | output | 1 | Downstream security attribute |
| dn_rsp_valid | input | 1 | Slave response valid |
| dn_rsp_ready | output | 1 | Gate takes slave response |
| dn_rsp_rdata | input | 32 | Slave read data |
| dn_rsp_err | input | 1 | Slave error flag |

## Verification
The bench targets several corner cases of the filter, the bank and the response path:

- **Refused requests.** A nonsecure write to the bank must leave it untouched. A gate that let it through would hand the security map to untrusted software.
- **Nonsecure bank reads.** These are checked against the real contents. A leaky gate would return the settings.
- **Security bit clear, filter bit set.** This case catches a gate that checks only one of the two bits.
- **Error enable.** Tests toggle it to show that refused accesses switch from random-data OKAY to error.
- **Response timing.** The bench counts the cycles from acceptance to response, to catch a refused request that was forwarded or delayed.
- **Back-pressure.** Tests stall both `rsp_ready` and the downstream ready to catch fields that change while held.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  typedef enum logic [1:0] {
    SG_IDLE = 2'd0,
    SG_FWD  = 2'd1,
    SG_WAIT = 2'd2,
    SG_RESP = 2'd3
  } sg_state_e;

  localparam logic [1:0] OFF_SEC  = 2'd0;
  localparam logic [1:0] OFF_PRIV = 2'd1;
  localparam logic [1:0] OFF_CTRL = 2'd2;

  localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;
endpackage

// File: rtl/sgw_lfsr.sv
module sgw_lfsr #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] TAPS = sgw_pkg::LFSR_TAPS,
  parameter logic [W-1:0] SEED = 32'h1ACE_B00C
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= {1'b0, st_q[W-1:1]} ^ (st_q[0] ? TAPS : '0);
  end

  assign state_o = st_q;
endmodule

// File: rtl/sgw_rule.sv
module sgw_rule #(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned NSLV = 1 << IDX_W
) (
  input  logic [NSLV-1:0]  sec_bits,
  input  logic [NSLV-1:0]  priv_bits,
  input  logic [IDX_W-1:0] idx,
  input  logic             secure,
  output logic             pass
);
  logic [NSLV-1:0] permit;

  for (genvar i = 0; i < NSLV; i++) begin : g_slv
    assign permit[i] = (secure || !sec_bits[i]) && (secure || !priv_bits[i]);
  end

  assign pass = permit[idx];
endmodule

// File: rtl/sgw_regs.sv
module sgw_regs #(
  parameter int unsigned NSLV = 16,
  parameter int unsigned DW   = 32,
  parameter logic [NSLV-1:0] PRIV_RST = 16'h0F00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [1:0]      off,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [NSLV-1:0] sec_q,
  output logic [NSLV-1:0] priv_q,
  output logic            errmode_q
);
  import sgw_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_q     <= '1;
      priv_q    <= PRIV_RST;
      errmode_q <= 1'b0;
    end else if (we) begin
      case (off)
        OFF_SEC:  sec_q     <= wdata[NSLV-1:0];
        OFF_PRIV: priv_q    <= wdata[NSLV-1:0];
        OFF_CTRL: errmode_q <= wdata[0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    rdata = '0;
    case (off)
      OFF_SEC:  rdata[NSLV-1:0] = sec_q;
      OFF_PRIV: rdata[NSLV-1:0] = priv_q;
      OFF_CTRL: rdata[0]        = errmode_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/sec_gate.sv
module sec_gate #(
  parameter int unsigned AW      = 32,
  parameter int unsigned DW      = 32,
  parameter int unsigned IDX_LSB = 12,
  parameter int unsigned IDX_W   = 4,
  parameter logic [(1<<IDX_W)-1:0] PRIV_RST = 16'h0F00,
  parameter logic [31:0] LFSR_SEED = 32'h1ACE_B00C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_secure,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_err,
  output logic          dn_req_valid,
  input  logic          dn_req_ready,
  output logic [AW-1:0] dn_addr,
  output logic          dn_write,
  output logic [DW-1:0] dn_wdata,
  output logic          dn_secure,
  input  logic          dn_rsp_valid,
  output logic          dn_rsp_ready,
  input  logic [DW-1:0] dn_rsp_rdata,
  input  logic          dn_rsp_err
);
  import sgw_pkg::*;

  localparam int unsigned NSLV = 1 << IDX_W;
  localparam logic [IDX_W-1:0] BANK_IDX = IDX_W'(NSLV - 1);

  sg_state_e state_q;

  logic [IDX_W-1:0] idx_w;
  logic             pass_w;
  logic             blk_w;
  logic             acc;
  logic             bank_w;
  logic             reg_we;
  logic [DW-1:0]    reg_rdata;
  logic [NSLV-1:0]  sec_q;
  logic [NSLV-1:0]  priv_q;
  logic             errmode_q;
  logic [31:0]      lfsr_q;
  logic [DW-1:0]    rnd_w;

  logic [AW-1:0]    dn_addr_q;
  logic             dn_write_q;
  logic [DW-1:0]    dn_wdata_q;
  logic             dn_secure_q;
  logic [DW-1:0]    rsp_rdata_q;
  logic             rsp_err_q;

  assign idx_w  = req_addr[IDX_LSB +: IDX_W];
  assign acc    = req_valid && req_ready;
  assign blk_w  = !pass_w;
  assign bank_w = (idx_w == BANK_IDX);
  assign reg_we = acc && pass_w && bank_w && req_write && req_secure;

  if (DW > 32) begin : g_rnd_wide
    assign rnd_w = {{(DW-32){1'b0}}, lfsr_q};
  end else begin : g_rnd_narrow
    assign rnd_w = lfsr_q[DW-1:0];
  end

  sgw_lfsr #(
    .W    (32),
    .TAPS (LFSR_TAPS),
    .SEED (LFSR_SEED)
  ) u_lfsr (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_o (lfsr_q)
  );

  sgw_rule #(
    .IDX_W (IDX_W)
  ) u_rule (
    .sec_bits  (sec_q),
    .priv_bits (priv_q),
    .idx       (idx_w),
    .secure    (req_secure),
    .pass      (pass_w)
  );

  sgw_regs #(
    .NSLV     (NSLV),
    .DW       (DW),
    .PRIV_RST (PRIV_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .off       (req_addr[3:2]),
    .wdata     (req_wdata),
    .rdata     (reg_rdata),
    .sec_q     (sec_q),
    .priv_q    (priv_q),
    .errmode_q (errmode_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= SG_IDLE;
      dn_addr_q   <= '0;
      dn_write_q  <= 1'b0;
      dn_wdata_q  <= '0;
      dn_secure_q <= 1'b0;
      rsp_rdata_q <= '0;
      rsp_err_q   <= 1'b0;
    end else begin
      case (state_q)
        SG_IDLE: begin
          if (acc) begin
            if (blk_w) begin
              rsp_err_q   <= errmode_q;
              rsp_rdata_q <= (req_write || errmode_q) ? '0 : rnd_w;
              state_q     <= SG_RESP;
            end else if (bank_w) begin
              rsp_err_q   <= 1'b0;
              rsp_rdata_q <= req_write ? '0 : reg_rdata;
              state_q     <= SG_RESP;
            end else begin
              dn_addr_q   <= req_addr;
              dn_write_q  <= req_write;
              dn_wdata_q  <= req_wdata;
              dn_secure_q <= req_secure;
              state_q     <= SG_FWD;
            end
          end
        end
        SG_FWD: begin
          if (dn_req_ready) state_q <= SG_WAIT;
        end
        SG_WAIT: begin
          if (dn_rsp_valid) begin
            rsp_rdata_q <= dn_rsp_rdata;
            rsp_err_q   <= dn_rsp_err;
            state_q     <= SG_RESP;
          end
        end
        SG_RESP: begin
          if (rsp_ready) state_q <= SG_IDLE;
        end
        default: state_q <= SG_IDLE;
      endcase
    end
  end

  assign req_ready    = (state_q == SG_IDLE);
  assign rsp_valid    = (state_q == SG_RESP);
  assign rsp_rdata    = rsp_rdata_q;
  assign rsp_err      = rsp_err_q;
  assign dn_req_valid = (state_q == SG_FWD);
  assign dn_rsp_ready = (state_q == SG_WAIT);
  assign dn_addr      = dn_addr_q;
  assign dn_write     = dn_write_q;
  assign dn_wdata     = dn_wdata_q;
  assign dn_secure    = dn_secure_q;
endmodule

// File: rtl/sgw_chk.sv
module sgw_chk #(
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned NSLV  = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            req_write,
  input logic            req_secure,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [DW-1:0]   rsp_rdata,
  input logic            rsp_err,
  input logic            dn_req_valid,
  input logic            dn_req_ready,
  input logic [AW-1:0]   dn_addr,
  input logic            dn_write,
  input logic [DW-1:0]   dn_wdata,
  input logic            acc,
  input logic            blk_w,
  input logic            bank_w,
  input logic [NSLV-1:0] sec_q,
  input logic [NSLV-1:0] priv_q,
  input logic [31:0]     lfsr_q
);
  p_ready_only_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || dn_req_valid) |-> !req_ready);

  p_rsp_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err)));

  p_dn_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req_valid && !dn_req_ready) |=>
      (dn_req_valid && $stable(dn_addr) && $stable(dn_write) && $stable(dn_wdata)));

  p_refused_no_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && blk_w) |=> !dn_req_valid);

  p_local_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (blk_w || bank_w)) |=> rsp_valid);

  p_ns_write_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && !req_secure) |=> ($stable(sec_q) && $stable(priv_q)));

  p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != 32'd0);

  p_lfsr_moves_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (lfsr_q != $past(lfsr_q)));
endmodule

bind sec_gate sgw_chk #(
  .AW   (AW),
  .DW   (DW),
  .NSLV (1 << IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_secure   (req_secure),
  .rsp_valid    (rsp_valid),
  .rsp_ready    (rsp_ready),
  .rsp_rdata    (rsp_rdata),
  .rsp_err      (rsp_err),
  .dn_req_valid (dn_req_valid),
  .dn_req_ready (dn_req_ready),
  .dn_addr      (dn_addr),
  .dn_write     (dn_write),
  .dn_wdata     (dn_wdata),
  .acc          (acc),
  .blk_w        (blk_w),
  .bank_w       (bank_w),
  .sec_q        (sec_q),
  .priv_q       (priv_q),
  .lfsr_q       (lfsr_q)
);

// File: tb/sim_sec_gate.sv
module sim_sec_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [31:0] req_wdata = '0;
  logic        req_secure = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        rsp_err;
  logic        dn_req_valid;
  logic        dn_req_ready = 1'b0;
  logic [31:0] dn_addr;
  logic        dn_write;
  logic [31:0] dn_wdata;
  logic        dn_secure;
  logic        dn_rsp_valid = 1'b0;
  logic        dn_rsp_ready;
  logic [31:0] dn_rsp_rdata = '0;
  logic        dn_rsp_err = 1'b0;

  always #2 clk = ~clk;

  sec_gate u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_wdata(req_wdata), .req_secure(req_secure),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_addr(dn_addr),
    .dn_write(dn_write), .dn_wdata(dn_wdata), .dn_secure(dn_secure),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_ready(dn_rsp_ready),
    .dn_rsp_rdata(dn_rsp_rdata), .dn_rsp_err(dn_rsp_err)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench mirror of the register bank
  logic [15:0] m_sec;
  logic [15:0] m_priv;
  logic        m_err;

  // slave model
  int          s_cnt = 0;
  logic [31:0] s_addr = '0;
  logic        s_wr = 1'b0;
  logic [31:0] s_wd = '0;
  logic        s_sec = 1'b0;
  int          s_wait = 0;
  bit          s_pend = 0;

  function automatic logic [31:0] sdat(logic [31:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h1357_9BDF;
  endfunction

  function automatic logic serr(logic [31:0] a);
    return a[11:4] == 8'hEE;
  endfunction

  function automatic bit exp_pass(logic [3:0] i, logic s);
    return (s || !m_sec[i]) && (s || !m_priv[i]);
  endfunction

  always @(negedge clk) dn_req_ready <= ($urandom % 3) != 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      dn_rsp_valid <= 1'b0;
      s_pend <= 0;
    end else begin
      if (dn_req_valid && dn_req_ready) begin
        s_cnt  <= s_cnt + 1;
        s_addr <= dn_addr;
        s_wr   <= dn_write;
        s_wd   <= dn_wdata;
        s_sec  <= dn_secure;
        s_pend <= 1;
        s_wait <= 1 + ($urandom % 3);
      end else if (s_pend) begin
        if (s_wait > 0) s_wait <= s_wait - 1;
        else begin
          s_pend       <= 0;
          dn_rsp_valid <= 1'b1;
          dn_rsp_rdata <= s_wr ? 32'd0 : sdat(s_addr);
          dn_rsp_err   <= serr(s_addr);
        end
      end
      if (dn_rsp_valid && dn_rsp_ready) dn_rsp_valid <= 1'b0;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  // one transaction; returns data, error and the ack latency flag
  task automatic txn(input logic [31:0] a, input logic w, input logic [31:0] wd,
                     input logic s, output logic [31:0] rd, output logic er,
                     output logic first);
    bit rdy;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_wdata = wd; req_secure = s;
    forever begin
      rdy = req_ready;
      @(posedge clk);
      @(negedge clk);
      if (rdy) break;
    end
    req_valid = 1'b0;
    first = rsp_valid;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    er = rsp_err;
    @(posedge clk);
  endtask

  // transaction checked against the mirror model
  task automatic mtxn(input logic [31:0] a, input logic w, input logic [31:0] wd,
                      input logic s, input string tag);
    logic [31:0] rd;
    logic er, first;
    int c0;
    bit p;
    logic [3:0] ix;
    ix = a[15:12];
    p  = exp_pass(ix, s);
    c0 = s_cnt;
    txn(a, w, wd, s, rd, er, first);
    if (!p) begin
      chk(s_cnt == c0, {tag, " R2 not forwarded"}, s_cnt, c0);
      chk(first, {tag, " R9 next-cycle ack"}, first, 1);
      chk(er == m_err, {tag, " R6 status"}, er, m_err);
      if (w || m_err) chk(rd == 0, {tag, " R6 zero data"}, rd, 0);
      else            chk(rd != 0, {tag, " R8 random data"}, rd, 1);
    end else if (ix == 4'hF) begin
      logic [31:0] e;
      chk(first, {tag, " R9 bank ack"}, first, 1);
      e = 0;
      if (!w) case (a[3:2])
        2'd0: e = {16'd0, m_sec};
        2'd1: e = {16'd0, m_priv};
        2'd2: e = {31'd0, m_err};
        default: e = 0;
      endcase
      chk(rd == e && er == 0, {tag, " R10 bank data"}, rd, e);
      if (w && s) case (a[3:2])
        2'd0: m_sec = wd[15:0];
        2'd1: m_priv = wd[15:0];
        2'd2: m_err = wd[0];
        default: ;
      endcase
    end else begin
      logic [31:0] e;
      e = w ? 32'd0 : sdat(a);
      chk(s_cnt == c0 + 1, {tag, " R3 forwarded"}, s_cnt, c0 + 1);
      chk(s_addr == a && s_wr == w && s_sec == s && (!w || s_wd == wd),
          {tag, " R3 fields"}, s_addr, a);
      chk(rd == e && er == serr(a), {tag, " R3 response"}, rd, e);
    end
  endtask

  initial begin
    logic [31:0] rd, rd2;
    logic er, first;
    void'($urandom(32'h5EED_0042));
    m_sec = 16'hFFFF; m_priv = 16'h0F00; m_err = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !dn_req_valid, "R11 idle after reset",
        {req_ready, rsp_valid, dn_req_valid}, 3'b100);

    // R1 reset contents, R10 offsets
    txn(32'h0000_F000, 0, 0, 1, rd, er, first);
    chk(rd == 32'h0000_FFFF, "R1 security bits", rd, 32'h0000_FFFF);
    txn(32'h0000_F004, 0, 0, 1, rd, er, first);
    chk(rd == 32'h0000_0F00, "R1 filter mask", rd, 32'h0000_0F00);
    txn(32'h0000_F008, 0, 0, 1, rd, er, first);
    chk(rd == 0, "R1 error enable", rd, 0);
    txn(32'h0000_F00C, 0, 0, 1, rd, er, first);
    chk(rd == 0, "R10 unused offset", rd, 0);

    // R2 / R6 / R9 nonsecure to secure slave
    mtxn(32'h0000_3010, 0, 0, 0, "ns read slave3");
    mtxn(32'h0000_3010, 1, 32'hDEAD_0001, 0, "ns write slave3");
    // R3 secure passes
    mtxn(32'h0000_3010, 0, 0, 1, "s read slave3");
    mtxn(32'h0000_2EE0, 0, 0, 1, "s read slave err");

    // R4 nonsecure write to bank is ignored
    txn(32'h0000_F000, 1, 32'h0, 0, rd, er, first);
    txn(32'h0000_F000, 0, 0, 1, rd, er, first);
    chk(rd == 32'h0000_FFFF, "R4 ns write kept bank", rd, 32'h0000_FFFF);

    // R5 / R8 nonsecure bank reads
    txn(32'h0000_F000, 0, 0, 0, rd, er, first);
    chk(rd != 32'h0000_FFFF && rd != 0 && !er, "R5 ns bank read hidden", rd, 32'h0000_FFFF);
    txn(32'h0000_F004, 0, 0, 0, rd2, er, first);
    chk(rd2 != rd, "R8 successive random differ", rd2, rd);

    // open slaves except bank; R7 filter on 8..11
    mtxn(32'h0000_F000, 1, 32'h0000_8000, 1, "s write sec");
    mtxn(32'h0000_3020, 0, 0, 0, "ns read open slave3");
    mtxn(32'h0000_9020, 0, 0, 0, "R7 ns read filtered slave9");
    txn(32'h0000_9020, 0, 0, 0, rd, er, first);
    chk(first && !er, "R7 filter refuses", first, 1);
    mtxn(32'h0000_F004, 1, 32'h0, 1, "s write priv");
    mtxn(32'h0000_9024, 0, 0, 0, "R7 unfiltered slave9");

    // R6 error mode
    mtxn(32'h0000_F008, 1, 32'h1, 1, "s set errmode");
    txn(32'h0000_F000, 0, 0, 0, rd, er, first);
    chk(er && rd == 0, "R6 error response", {31'd0, er}, 1);
    mtxn(32'h0000_F000, 1, 32'h0, 0, "R4 ns bank write err");
    mtxn(32'h0000_F008, 1, 32'h0, 1, "s clear errmode");

    // R11 response back-pressure
    @(negedge clk);
    rsp_ready = 1'b0;
    txn(32'h0000_2030, 0, 0, 1, rd, er, first);
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid && rsp_rdata == rd, "R11 response held", rsp_rdata, rd);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!rsp_valid && rd == sdat(32'h0000_2030), "R11 response released", rd, sdat(32'h0000_2030));

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      logic [3:0] ix;
      ix = ($urandom % 4 == 0) ? 4'hF : 4'($urandom % 15);
      a = {16'h0, ix, 12'($urandom) & 12'hFFC};
      if (ix == 4'hF && a[3:2] == 2'd0 && ($urandom % 2 == 0)) a[3:2] = 2'd1;
      mtxn(a, 1'($urandom), $urandom, 1'($urandom), "random");
    end
    finish_run();
  end
endmodule